// File: doc/BRIEF.md
# Control-Transfer Misalignment Trap Unit

This unit sits in the execute stage of a simple in-order RISC-V style pipeline. Each cycle it may see one control transfer: a conditional branch, a direct jump-and-link or a register-indirect jump-and-link. With it come the current PC, the computed target, the branch outcome, a request to write the link register and a flag that says whether compressed (16-bit) instructions are supported.

When the transfer is taken and its target is aligned, the unit passes the redirect to the fetch front end. It also lets the link write through. When a taken transfer points to a target that is not aligned, the fault is caught at that instruction. The link-register write is dropped and no redirect reaches the fetch unit. On the next clock edge the unit raises a one-cycle instruction-address-misaligned trap request. The request carries the cause code, the exception PC and the faulting target as the trap value.

Top module: `jtrap_unit`

## Requirements
- R1: `xfer_kind_i` encodes 2'b00 conditional branch, 2'b01 direct jump, 2'b10 register-indirect jump and 2'b11 no transfer. The effective target equals `target_i`, except that for the register-indirect jump bit 0 is cleared. A taken, aligned transfer with `xfer_valid_i` high drives `redirect_valid_o` high in the same cycle, and `redirect_addr_o` equals the effective target.
- R2: A target is misaligned exactly when bit 1 of the effective target is 1 and `rvc_en_i` is 0. With `rvc_en_i` high, a target with bit 1 set is treated as aligned and is redirected.
- R3: A taken transfer to a misaligned target never raises `redirect_valid_o`.
- R4: `link_we_o` equals `link_we_i`, except that it is 0 in a cycle where a taken transfer has a misaligned target.
- R5: A taken misaligned transfer makes `trap_req_o` high for exactly the one cycle after the next rising clock edge. At that point `trap_tval_o` equals the effective target. Two offending transfers in consecutive cycles give two consecutive pulses.
- R6: When `trap_req_o` is high, `trap_epc_o` equals the PC of the offending instruction with bit 0 forced to 0.
- R7: When `trap_req_o` is high, `trap_cause_o` is 0 and `trap_irq_o` is 0.
- R8: A conditional branch with `br_taken_i` low never raises a trap or a redirect, whatever its target.
- R9: While `rst_ni` is low, and after it is released, `trap_req_o` is 0 and `trap_epc_o` and `trap_tval_o` are 0 until the first offending transfer.
- R10: With `xfer_valid_i` low, or with kind 2'b11, there is no redirect and no trap, and the link write passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xfer_valid_i | input | 1 | A control transfer is in execute this cycle |
| xfer_kind_i | input | 2 | Transfer kind (see R1) |
| br_taken_i | input | 1 | Conditional branch outcome |
| rvc_en_i | input | 1 | Compressed instructions supported |
| pc_i | input | XLEN | PC of the instruction in execute |
| target_i | input | XLEN | Computed transfer target |
| link_we_i | input | 1 | Link-register write request |
| link_we_o | output | 1 | Gated link-register write enable |
| redirect_valid_o | output | 1 | Fetch redirect request |
| redirect_addr_o | output | XLEN | Fetch redirect address |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_irq_o | output | 1 | Interrupt bit of the trap cause |
| trap_cause_o | output | 5 | Trap cause code |
| trap_epc_o | output | XLEN | Exception PC |
| trap_tval_o | output | XLEN | Trap value (faulting target) |

## Verification
The hardest case to reach is a register-indirect jump whose raw target has both bit 0 and bit 1 set. The clearing of bit 0 and the alignment check then interact, and the trap value must show the cleared address. It is harder still when such jumps come back to back, so the trap request has to stay high for two cycles with different values. Directed sequences place these cases explicitly, with compressed support both on and off. A long pseudo-random run then mixes kinds, outcomes and low target bits. Every clock is compared against a behavioural model kept in the bench.

// File: rtl/jtrap_pkg.sv
package jtrap_pkg;

    typedef enum logic [1:0] {
        XFER_BRANCH = 2'b00,
        XFER_JAL    = 2'b01,
        XFER_JALR   = 2'b10,
        XFER_NONE   = 2'b11
    } xfer_kind_e;

    localparam int unsigned CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_INSTR_MISALIGN = '0;

endpackage

// File: rtl/jtrap_target_chk.sv
module jtrap_target_chk
    import jtrap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [1:0]      kind_i,
    input  logic [XLEN-1:0] target_i,
    input  logic            rvc_en_i,
    output logic [XLEN-1:0] eff_target_o,
    output logic            misaligned_o
);

    always_comb begin
        eff_target_o = target_i;
        if (xfer_kind_e'(kind_i) == XFER_JALR) begin
            eff_target_o[0] = 1'b0;
        end
        // Half-word targets are legal only when compressed code exists
        misaligned_o = eff_target_o[1] & ~rvc_en_i;
    end

endmodule

// File: rtl/jtrap_xfer_gate.sv
module jtrap_xfer_gate
    import jtrap_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] kind_i,
    input  logic       br_taken_i,
    input  logic       misaligned_i,
    input  logic       link_we_i,
    output logic       fire_o,
    output logic       redirect_valid_o,
    output logic       link_we_o
);

    logic taken;

    always_comb begin
        unique case (xfer_kind_e'(kind_i))
            XFER_BRANCH: taken = valid_i & br_taken_i;
            XFER_JAL,
            XFER_JALR:   taken = valid_i;
            default:     taken = 1'b0;
        endcase
        fire_o           = taken & misaligned_i;
        redirect_valid_o = taken & ~misaligned_i;
        link_we_o        = link_we_i & ~fire_o;
    end

endmodule

// File: rtl/jtrap_trap_reg.sv
module jtrap_trap_reg
    import jtrap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fire_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    eff_target_i,
    output logic               req_o,
    output logic               irq_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    tval_o
);

    typedef struct packed {
        logic               req;
        logic               irq;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    epc;
        logic [XLEN-1:0]    tval;
    } trap_state_t;

    trap_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = fire_i;
        if (fire_i) begin
            st_d.irq   = 1'b0;
            st_d.cause = CAUSE_INSTR_MISALIGN;
            st_d.epc   = {pc_i[XLEN-1:1], 1'b0};
            st_d.tval  = eff_target_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o   = st_q.req;
    assign irq_o   = st_q.irq;
    assign cause_o = st_q.cause;
    assign epc_o   = st_q.epc;
    assign tval_o  = st_q.tval;

endmodule

// File: rtl/jtrap_unit.sv
module jtrap_unit
    import jtrap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               xfer_valid_i,
    input  logic [1:0]         xfer_kind_i,
    input  logic               br_taken_i,
    input  logic               rvc_en_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    target_i,
    input  logic               link_we_i,
    output logic               link_we_o,
    output logic               redirect_valid_o,
    output logic [XLEN-1:0]    redirect_addr_o,
    output logic               trap_req_o,
    output logic               trap_irq_o,
    output logic [CAUSE_W-1:0] trap_cause_o,
    output logic [XLEN-1:0]    trap_epc_o,
    output logic [XLEN-1:0]    trap_tval_o
);

    logic [XLEN-1:0] eff_target;
    logic            misaligned;
    logic            fire;

    jtrap_target_chk #(.XLEN(XLEN)) u_target (
        .kind_i      (xfer_kind_i),
        .target_i    (target_i),
        .rvc_en_i    (rvc_en_i),
        .eff_target_o(eff_target),
        .misaligned_o(misaligned)
    );

    jtrap_xfer_gate u_gate (
        .valid_i         (xfer_valid_i),
        .kind_i          (xfer_kind_i),
        .br_taken_i      (br_taken_i),
        .misaligned_i    (misaligned),
        .link_we_i       (link_we_i),
        .fire_o          (fire),
        .redirect_valid_o(redirect_valid_o),
        .link_we_o       (link_we_o)
    );

    jtrap_trap_reg #(.XLEN(XLEN)) u_trap (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fire_i      (fire),
        .pc_i        (pc_i),
        .eff_target_i(eff_target),
        .req_o       (trap_req_o),
        .irq_o       (trap_irq_o),
        .cause_o     (trap_cause_o),
        .epc_o       (trap_epc_o),
        .tval_o      (trap_tval_o)
    );

    assign redirect_addr_o = eff_target;

endmodule

// File: rtl/jtrap_unit_chk.sv
module jtrap_unit_chk
    import jtrap_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               xfer_valid_i,
    input logic [1:0]         xfer_kind_i,
    input logic               br_taken_i,
    input logic               rvc_en_i,
    input logic               link_we_i,
    input logic               link_we_o,
    input logic               redirect_valid_o,
    input logic [XLEN-1:0]    redirect_addr_o,
    input logic               trap_req_o,
    input logic               trap_irq_o,
    input logic [CAUSE_W-1:0] trap_cause_o,
    input logic [XLEN-1:0]    trap_epc_o,
    input logic [XLEN-1:0]    trap_tval_o
);

    // R3
    redirect_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_valid_o |-> !(redirect_addr_o[1] && !rvc_en_i));

    // R4
    link_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> !$past(link_we_o));

    // R5
    tval_misaligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> (trap_tval_o[1] && !$past(rvc_en_i)));

    // R6
    epc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> !trap_epc_o[0]);

    // R7
    cause_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> (trap_cause_o == CAUSE_INSTR_MISALIGN && !trap_irq_o));

    // R8
    not_taken_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_valid_i && xfer_kind_i == 2'b00 && !br_taken_i) |=> !trap_req_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!xfer_valid_i || xfer_kind_i == 2'b11) |-> (!redirect_valid_o && link_we_o == link_we_i));

endmodule

bind jtrap_unit jtrap_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .xfer_valid_i    (xfer_valid_i),
    .xfer_kind_i     (xfer_kind_i),
    .br_taken_i      (br_taken_i),
    .rvc_en_i        (rvc_en_i),
    .link_we_i       (link_we_i),
    .link_we_o       (link_we_o),
    .redirect_valid_o(redirect_valid_o),
    .redirect_addr_o (redirect_addr_o),
    .trap_req_o      (trap_req_o),
    .trap_irq_o      (trap_irq_o),
    .trap_cause_o    (trap_cause_o),
    .trap_epc_o      (trap_epc_o),
    .trap_tval_o     (trap_tval_o)
);

// File: tb/jtrap_unit_tb_top.sv
module jtrap_unit_tb_top;

    localparam int unsigned XLEN   = 32;
    localparam time         CLK_PER = 10ns;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            xv;
    logic [1:0]      kind;
    logic            tk;
    logic            rvc;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] tgt;
    logic            lwe_i;
    logic            lwe_o;
    logic            rd_v;
    logic [XLEN-1:0] rd_a;
    logic            t_req;
    logic            t_irq;
    logic [4:0]      t_cause;
    logic [XLEN-1:0] t_epc;
    logic [XLEN-1:0] t_tval;

    int checks = 0;
    int fails  = 0;

    // model state for registered outputs
    logic            m_req  = 1'b0;
    logic [XLEN-1:0] m_epc  = '0;
    logic [XLEN-1:0] m_tval = '0;

    always #(CLK_PER/2) clk = ~clk;

    jtrap_unit #(.XLEN(XLEN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .xfer_valid_i(xv), .xfer_kind_i(kind),
        .br_taken_i(tk), .rvc_en_i(rvc), .pc_i(pc), .target_i(tgt),
        .link_we_i(lwe_i), .link_we_o(lwe_o), .redirect_valid_o(rd_v),
        .redirect_addr_o(rd_a), .trap_req_o(t_req), .trap_irq_o(t_irq),
        .trap_cause_o(t_cause), .trap_epc_o(t_epc), .trap_tval_o(t_tval)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " R5 trap_req"}, XLEN'(t_req), XLEN'(m_req));
        if (m_req) begin
            chk({tag, " R5 tval"}, t_tval, m_tval);
            chk({tag, " R6 epc"}, t_epc, m_epc);
            chk({tag, " R7 cause"}, XLEN'(t_cause), '0);
            chk({tag, " R7 irq"}, XLEN'(t_irq), '0);
        end else begin
            chk({tag, " R9 held tval"}, t_tval, m_tval);
            chk({tag, " R9 held epc"}, t_epc, m_epc);
        end
    endtask

    // one cycle: check registered outputs, drive, check combinational, advance model
    task automatic step(input logic v, input logic [1:0] k, input logic t, input logic c,
                        input logic [XLEN-1:0] p, input logic [XLEN-1:0] a, input logic l);
        logic [XLEN-1:0] eff;
        logic taken, mis, fire;
        check_regs("pre");
        xv = v; kind = k; tk = t; rvc = c; pc = p; tgt = a; lwe_i = l;
        #1;
        eff = a;
        if (k == 2'b10) eff[0] = 1'b0;
        taken = v && (k == 2'b01 || k == 2'b10 || (k == 2'b00 && t));
        mis   = eff[1] && !c;
        fire  = taken && mis;
        chk("R1/R3/R8/R10 redirect_valid", XLEN'(rd_v), XLEN'(taken && !mis));
        if (taken && !mis) chk("R1/R2 redirect_addr", rd_a, eff);
        chk("R4 link_we", XLEN'(lwe_o), XLEN'(l && !fire));
        @(posedge clk);
        m_req = fire;
        if (fire) begin
            m_tval = eff;
            m_epc  = {p[XLEN-1:1], 1'b0};
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PER * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2345;
        rst_n = 1'b0; xv = 0; kind = 0; tk = 0; rvc = 0; pc = 0; tgt = 0; lwe_i = 0;
        // reset state while stimulus claims an offending jump (R9)
        @(negedge clk);
        xv = 1; kind = 2'b01; tgt = 32'h0000_0102; pc = 32'h0000_0041;
        @(posedge clk); @(negedge clk);
        chk("R9 reset trap_req", XLEN'(t_req), '0);
        chk("R9 reset tval", t_tval, '0);
        chk("R9 reset epc", t_epc, '0);
        rst_n = 1'b1;
        // R1 aligned direct jump with link
        step(1, 2'b01, 0, 0, 32'h0000_1000, 32'h0000_2000, 1);
        // R3 R4 R5 R6 misaligned direct jump, odd pc
        step(1, 2'b01, 0, 0, 32'h0000_1005, 32'h0000_2002, 1);
        step(0, 2'b00, 0, 0, 32'h0, 32'h0, 0);
        // R2 same target allowed with compressed
        step(1, 2'b01, 0, 1, 32'h0000_1008, 32'h0000_2002, 1);
        // R1 register-indirect bit0 cleared, aligned
        step(1, 2'b10, 0, 0, 32'h0000_1010, 32'h0000_3001, 1);
        // R5 register-indirect bits 1 and 0 set, back to back offenders
        step(1, 2'b10, 0, 0, 32'h0000_1014, 32'h0000_3003, 1);
        step(1, 2'b00, 1, 0, 32'h0000_1018, 32'h0000_4006, 0);
        step(1, 2'b10, 0, 0, 32'h0000_101C, 32'hFFFF_FFFF, 1);
        // R8 not-taken branch with bad target
        step(1, 2'b00, 0, 0, 32'h0000_1020, 32'h0000_5002, 0);
        // R10 invalid and no-transfer kind
        step(0, 2'b01, 0, 0, 32'h0000_1024, 32'h0000_6002, 1);
        step(1, 2'b11, 1, 0, 32'h0000_1028, 32'h0000_6006, 1);
        // R1 taken aligned branch
        step(1, 2'b00, 1, 0, 32'h0000_102C, 32'h0000_7000, 0);
        // mixed pseudo-random run
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0] | lfsr[7], lfsr[2:1], lfsr[3], lfsr[4] & lfsr[9],
                 {lfsr[27:12], lfsr[11:0], 3'b0, lfsr[5]},
                 {lfsr[31:8], 6'b0, lfsr[6], lfsr[5] & (lfsr[2:1] == 2'b10)}, lfsr[8]);
        end
        step(0, 2'b00, 0, 0, 32'h0, 32'h0, 0);
        check_regs("end");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule